// File: doc/BRIEF.md
# Supply Fault Latch Sequencer

This block is the digital control core of a power-supply supervisor. It receives an active-low on/off request from the host board, digital comparator flags that report overvoltage on three rails and undervoltage on two, a flag that the power-good input is above its low threshold, and a one-microsecond timebase tick. It drives a fault-protect output that holds the main rails off. That output is high while the supply is commanded off or a fault is latched. The block also exports a registered fault-active flag, so the power-good logic can drop its output at once.

The on/off request is debounced symmetrically. Turn-on takes effect one clock after the debounce completes. Turn-off adds a further delay before the rails are released. Undervoltage detection is blanked for a window after turn-on, so a rail that is shorted at start-up cannot trip a false fault. Each fault flag must persist for its own deglitch time before it counts. An accepted fault is latched until the debounced request rises (turn-off) or reset is applied. All time constants are parameters in tick units. Every counter advances only on a tick and restarts when its condition drops.

Top module: `supply_fault_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the fault-protect output is 1 and the fault-active flag is 0; a reset also clears a latched fault.
- R2: A change of the on/off request in either direction takes effect only after it has been held for DEB_TICKS consecutive ticks; a shorter excursion has no effect on the outputs.
- R3: At turn-on the fault-protect output falls on the clock after the debounced request goes low, unless a fault is latched.
- R4: At turn-off the fault-protect output rises OFF_TICKS+1 clocks after the debounced request goes high.
- R5: An overvoltage flag (bit i of the 3-bit overvoltage input, rail i) latches a fault once it has stayed high for OV_TICKS ticks; a shorter pulse does not.
- R6: An undervoltage flag (bit i of the 2-bit undervoltage input) latches a fault once it has stayed high for UV_TICKS ticks while it is qualified.
- R7: Undervoltage flags are ignored for BLANK_TICKS ticks after the debounced request goes low.
- R8: Undervoltage flags are ignored while the power-good-input flag is 0; overvoltage flags latch regardless of that flag.
- R9: A latched fault holds both the fault-active flag and the fault-protect output at 1 until the clock after the debounced request rises, when the latch clears.
- R10: All timing counters advance only on cycles where the tick input is 1.
- R11: No fault is latched while the debounced request is high (supply off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| on_req_n_i | input | 1 | Active-low on/off request |
| ov_flag_i | input | NUM_OV | Overvoltage comparator flags, one per rail |
| uv_flag_i | input | NUM_UV | Undervoltage comparator flags, one per rail |
| pg_in_ok_i | input | 1 | Power-good input above its low threshold |
| fpo_o | output | 1 | Fault-protect output, 1 = rails off |
| fault_o | output | 1 | Registered fault-active flag |

## Verification
The case hardest to reach is the exact end of the undervoltage blanking window. The window opens only after a full request debounce. After that, a held undervoltage flag also needs its own deglitch time before it latches. The stimulus turns the supply on and raises an undervoltage flag just after turn-on. It then samples the fault flag one clock before and one clock after the latch is expected. The bench is built with short tick counts so that this boundary lands on a known clock.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // Width needed to count 0 .. n-1, never less than one bit.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Summary of deglitched fault sources for the latch.
    typedef struct packed {
        logic ov_any;
        logic uv_any;
    } fault_sum_t;

    // Supply command derived from the debounced request.
    typedef enum logic [1:0] {
        SUP_OFF     = 2'd0,
        SUP_ON      = 2'd1,
        SUP_OFF_DLY = 2'd2
    } sup_state_t;

endpackage

// File: rtl/sfs_deglitch.sv
// Qualifies a level: hit goes high after cond has held for HOLD ticks.
module sfs_deglitch #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic cond_i,
    output logic hit_o
);
    import sfs_pkg::*;

    localparam int unsigned W = cnt_w(HOLD);
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !cond_i) begin
            cnt_q <= '0;
            hit_o <= 1'b0;
        end else if (tick_i && !hit_o) begin
            if (cnt_q == LAST) begin
                hit_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfs_debounce.sv
// Debounced copy of the on/off request; resets to 1 (off).
module sfs_debounce #(
    parameter int unsigned TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic raw_i,
    output logic db_o
);
    import sfs_pkg::*;

    localparam int unsigned W = cnt_w(TICKS);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] cnt_q;
    logic         diff;

    assign diff = raw_i ^ db_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            db_o  <= 1'b1;
        end else if (!diff) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                db_o  <= raw_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfs_sequencer.sv
// Rail command with turn-off delay, and undervoltage blanking after turn-on.
module sfs_sequencer #(
    parameter int unsigned OFF_TICKS   = 5,
    parameter int unsigned BLANK_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic req_db_i,
    output logic rail_on_o,
    output logic uv_armed_o,
    output logic req_rise_o
);
    import sfs_pkg::*;

    sup_state_t state_q;
    logic       db_prev_q;
    logic       off_done;

    sfs_deglitch #(.HOLD(OFF_TICKS)) u_offdly (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .cond_i(req_db_i), .hit_o(off_done)
    );

    sfs_deglitch #(.HOLD(BLANK_TICKS)) u_blank (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .cond_i(!req_db_i), .hit_o(uv_armed_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SUP_OFF;
            db_prev_q <= 1'b1;
        end else begin
            db_prev_q <= req_db_i;
            unique case (state_q)
                SUP_OFF:     if (!req_db_i) state_q <= SUP_ON;
                SUP_ON:      if (req_db_i)  state_q <= SUP_OFF_DLY;
                SUP_OFF_DLY: begin
                    if (!req_db_i)     state_q <= SUP_ON;
                    else if (off_done) state_q <= SUP_OFF;
                end
                default:     state_q <= SUP_OFF;
            endcase
        end
    end

    // ON and OFF_DLY both keep the rails enabled; the ON entry is
    // taken on the clock after the debounced request falls.
    assign rail_on_o  = (state_q != SUP_OFF);
    assign req_rise_o = req_db_i & ~db_prev_q;
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq #(
    parameter int unsigned DEB_TICKS   = 38000,
    parameter int unsigned OFF_TICKS   = 2300,
    parameter int unsigned BLANK_TICKS = 75000,
    parameter int unsigned OV_TICKS    = 73,
    parameter int unsigned UV_TICKS    = 146,
    parameter int unsigned NUM_OV      = 3,
    parameter int unsigned NUM_UV      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              on_req_n_i,
    input  logic [NUM_OV-1:0] ov_flag_i,
    input  logic [NUM_UV-1:0] uv_flag_i,
    input  logic              pg_in_ok_i,
    output logic              fpo_o,
    output logic              fault_o
);
    import sfs_pkg::*;

    logic              req_db;
    logic              req_rise;
    logic              rail_on;
    logic              uv_armed;
    logic [NUM_OV-1:0] ov_hit;
    logic [NUM_UV-1:0] uv_hit;
    fault_sum_t        fsum;
    logic              latch_q;

    sfs_debounce #(.TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .raw_i(on_req_n_i), .db_o(req_db)
    );

    sfs_sequencer #(.OFF_TICKS(OFF_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_seq (
        .clk(clk), .rst(rst), .tick_i(tick_i), .req_db_i(req_db),
        .rail_on_o(rail_on), .uv_armed_o(uv_armed), .req_rise_o(req_rise)
    );

    for (genvar i = 0; i < NUM_OV; i++) begin : g_ov
        sfs_deglitch #(.HOLD(OV_TICKS)) u_dg (
            .clk(clk), .rst(rst), .tick_i(tick_i),
            .cond_i(ov_flag_i[i]), .hit_o(ov_hit[i])
        );
    end

    for (genvar j = 0; j < NUM_UV; j++) begin : g_uv
        sfs_deglitch #(.HOLD(UV_TICKS)) u_dg (
            .clk(clk), .rst(rst), .tick_i(tick_i),
            .cond_i(uv_flag_i[j] && uv_armed && pg_in_ok_i),
            .hit_o(uv_hit[j])
        );
    end

    assign fsum.ov_any = |ov_hit;
    assign fsum.uv_any = |uv_hit;

    // Clear on turn-off edge wins over a simultaneous set.
    always_ff @(posedge clk) begin
        if (rst || req_rise) begin
            latch_q <= 1'b0;
        end else if (!req_db && (fsum.ov_any || fsum.uv_any)) begin
            latch_q <= 1'b1;
        end
    end

    assign fault_o = latch_q;
    assign fpo_o   = ~rail_on | latch_q;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic req_db,
    input logic req_rise,
    input logic fpo_o,
    input logic fault_o
);
    // R9
    latch_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> fpo_o);

    // R9
    latch_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !req_rise) |=> fault_o);

    // R3
    on_releases_rails_chk: assert property (@(posedge clk) disable iff (rst)
        !req_db |=> (!fpo_o || fault_o));

    // R10
    request_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(req_db));

    // R11
    no_fault_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (req_db && !fault_o) |=> !fault_o);
endmodule

bind supply_fault_seq sfs_checker u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .req_db(req_db),
    .req_rise(req_rise), .fpo_o(fpo_o), .fault_o(fault_o)
);

// File: tb/sim_supply_fault_seq.sv
`timescale 1ns/1ps
module sim_supply_fault_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       req_n = 1'b1;
    logic [2:0] ov = '0;
    logic [1:0] uv = '0;
    logic       pgi = 1'b1;
    logic       fpo, flt;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    supply_fault_seq #(
        .DEB_TICKS(8), .OFF_TICKS(5), .BLANK_TICKS(20),
        .OV_TICKS(3), .UV_TICKS(6), .NUM_OV(3), .NUM_UV(2)
    ) u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .on_req_n_i(req_n),
        .ov_flag_i(ov), .uv_flag_i(uv), .pg_in_ok_i(pgi),
        .fpo_o(fpo), .fault_o(flt)
    );

    // {req_n, ov[2:0], uv[1:0], pgi, cycles[6:0], exp_fpo, exp_fault}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'b000, 2'b00, 1'b1, 7'd20, 1'b0, 1'b0}, // R2 R3 turn on
        {1'b0, 3'b001, 2'b00, 1'b1, 7'd10, 1'b1, 1'b1}, // R5 ov rail0
        {1'b0, 3'b000, 2'b00, 1'b1, 7'd10, 1'b1, 1'b1}, // R9 held
        {1'b1, 3'b000, 2'b00, 1'b1, 7'd20, 1'b1, 1'b0}, // R9 cleared
        {1'b0, 3'b000, 2'b00, 1'b1, 7'd40, 1'b0, 1'b0}, // R3 on again
        {1'b0, 3'b000, 2'b01, 1'b0, 7'd20, 1'b0, 1'b0}, // R8 uv gated
        {1'b0, 3'b000, 2'b01, 1'b1, 7'd10, 1'b1, 1'b1}, // R6 uv rail0
        {1'b1, 3'b000, 2'b00, 1'b1, 7'd20, 1'b1, 1'b0}, // R9 cleared
        {1'b1, 3'b100, 2'b00, 1'b1, 7'd20, 1'b1, 1'b0}, // R11 ov while off
        {1'b0, 3'b000, 2'b00, 1'b1, 7'd30, 1'b0, 1'b0}, // R11 nothing kept
        {1'b0, 3'b010, 2'b00, 1'b0, 7'd10, 1'b1, 1'b1}, // R8 ov ignores pgi
        {1'b1, 3'b000, 2'b00, 1'b1, 7'd20, 1'b1, 1'b0}  // R9 cleared
    };

    function automatic string vtag(input int i);
        case (i)
            0:       return "R3";
            1:       return "R5";
            2, 3, 7, 11: return "R9";
            4:       return "R3";
            5, 10:   return "R8";
            6:       return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    initial begin
        step(3);
        chk("R1", "fpo in reset", fpo, 1'b1);
        chk("R1", "fault in reset", flt, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R1", "fpo after reset", fpo, 1'b1);

        for (int i = 0; i < NV; i++) begin
            req_n = VEC[i][15];
            ov    = VEC[i][14:12];
            uv    = VEC[i][11:10];
            pgi   = VEC[i][9];
            step(int'(VEC[i][8:2]));
            chk(vtag(i), "table fpo", fpo, VEC[i][1]);
            chk(vtag(i), "table fault", flt, VEC[i][0]);
        end
        ov = '0; uv = '0; pgi = 1'b1;

        // R5 exact deglitch edges
        req_n = 1'b0; step(30);
        ov = 3'b001; step(2); ov = '0; step(5);
        chk("R5", "2-tick ov pulse", flt, 1'b0);
        ov = 3'b001; step(3);
        chk("R5", "ov before latch", flt, 1'b0);
        step(1);
        chk("R5", "ov latched", flt, 1'b1);
        ov = '0; req_n = 1'b1; step(20);

        // R2 short excursion ignored, then exact debounce
        req_n = 1'b0; step(7); req_n = 1'b1; step(10);
        chk("R2", "7-tick request glitch", fpo, 1'b1);
        req_n = 1'b0; step(8);
        chk("R2", "fpo at debounce edge", fpo, 1'b1);
        step(1);
        chk("R3", "fpo falls next clock", fpo, 1'b0);

        // R7 blanking boundary: armed after edge 28, uv hit 6 later, latch +1
        uv = 2'b01; step(25);
        chk("R7", "uv before window end", flt, 1'b0);
        step(1);
        chk("R7", "uv after window end", flt, 1'b1);
        uv = '0; req_n = 1'b1; step(8);
        chk("R9", "latch held until rise seen", flt, 1'b1);
        step(1);
        chk("R9", "latch cleared", flt, 1'b0);
        step(20);

        // R4 exact turn-off delay
        req_n = 1'b0; step(30);
        chk("R4", "on before turn-off", fpo, 1'b0);
        req_n = 1'b1; step(13);
        chk("R4", "fpo still low in delay", fpo, 1'b0);
        step(1);
        chk("R4", "fpo rises after delay", fpo, 1'b1);

        // R10 counters frozen without tick
        tick = 1'b0; req_n = 1'b0; step(50);
        chk("R10", "no tick no turn-on", fpo, 1'b1);
        tick = 1'b1; step(9);
        chk("R10", "turn-on once ticking", fpo, 1'b0);

        // R1 reset clears a latched fault
        ov = 3'b100; step(5);
        chk("R5", "ov rail2 latched", flt, 1'b1);
        rst = 1'b1; ov = '0; step(1);
        chk("R1", "reset clears fault", flt, 1'b0);
        chk("R1", "reset forces fpo", fpo, 1'b1);
        rst = 1'b0; req_n = 1'b1; step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule